// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One channel of a programmable interval timer. A controlling block loads a 16-bit period and a 3-bit operating mode, and the channel then counts the input clock-enable pulses (ticks). From the ticks that have elapsed since the last load or gate-triggered restart it produces an output waveform and a live count value that can be read back. Six behaviours are available: a terminal-count output that stays high, a retriggerable one-shot, a rate generator, a square-wave generator, and two single-tick strobes.

The gate input has one of two jobs, depending on the mode. In the terminal-count mode and the software-strobe mode, a low gate level freezes counting. In the one-shot, rate-generator, square-wave and hardware-strobe modes, a rising gate edge restarts the period from the loaded value. The channel counts in binary only. Register decoding and interrupt routing belong to the surrounding block, which drives the load port and reads the count port.

Top module: `intvl_chan`

## Requirements
- R1: After reset, and until the first load strobe, `out` is 0, `count_val` is 0 and ticks have no effect.
- R2: A loaded period of 0 acts as a period of 65536 ticks. Immediately after such a load, `count_val` reads 0 (the low 16 bits of 65536).
- R3: `load_stb` takes `load_val` and `mode_sel` at the clock edge and clears the elapsed-tick count. It has priority over a tick in the same cycle. Counting resumes on the next enabled tick.
- R4: In modes 0 and 1, `out` is 1 once the elapsed ticks reach the period N, and it stays 1. `count_val` is (N minus elapsed ticks) modulo 65536.
- R5: In mode 2, `count_val` is N minus (elapsed mod N). `out` is 1 for the single tick in which a whole number of periods has elapsed, and never at elapsed 0.
- R6: In mode 3, `out` is 1 while (elapsed mod N) is below ceil(N/2). `count_val` is N minus ((2 times elapsed) mod N), taken modulo 65536.
- R7: In modes 4 and 5, `out` is 1 only while the elapsed ticks equal N. `count_val` is (N minus elapsed) modulo 65536.
- R8: In modes 0 and 4, ticks are counted only while `gate` is 1. A gate rising edge does not restart the count.
- R9: In modes 1, 2, 3 and 5, the first clock edge that sees `gate` high after it was low restarts the elapsed count at 0. The gate level does not pause counting in these modes.
- R10: Mode codes 6 and 7 behave as modes 2 and 3 respectively.
- R11: While `tick_en` is 0, the elapsed count, `count_val` and `out` do not change, except through a load or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting tick enable |
| load_stb | input | 1 | Load period and mode |
| load_val | input | 16 | Period value (0 means 65536) |
| mode_sel | input | 3 | Operating mode code |
| gate | input | 1 | Gate input |
| out | output | 1 | Output waveform |
| count_val | output | 16 | Live count for readback |

## Verification
Every result appears on the ports as a combinational function of registers that update at the clock edge that accepts a load, a tick or a gate edge. Each result is therefore due one edge after its stimulus, with no further pipeline delay. The bench drives every input at the falling edge, lets exactly the intended number of ticking edges pass, drops `tick_en`, and samples at the next falling edge. The sampled value then reflects precisely the intended elapsed count. Gate tests add one idle edge around each gate change, so that the edge which sees the rise is the one that restarts.

// File: rtl/intvl_pkg.sv
package intvl_pkg;
  localparam int CW = 16;           // count width
  localparam int PW = CW + 1;       // period width (holds 2^CW)
  localparam int EW = CW + 1;       // saturating elapsed width

  typedef enum logic [2:0] {
    M_TERM   = 3'd0,
    M_ONESHOT= 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTRB = 3'd4,
    M_HWSTRB = 3'd5
  } chan_mode_e;

  // codes 6 and 7 fold onto rate and square
  function automatic chan_mode_e fold_mode(input logic [2:0] code);
    logic [2:0] m;
    m = (code > 3'd5) ? (code - 3'd4) : code;
    return chan_mode_e'(m);
  endfunction

  function automatic logic [PW-1:0] period_of(input logic [CW-1:0] v);
    return (v == '0) ? (PW'(1) << CW) : {1'b0, v};
  endfunction

  function automatic logic gate_pauses(input chan_mode_e m);
    return (m == M_TERM) || (m == M_SWSTRB);
  endfunction

  function automatic logic gate_retrigs(input chan_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTRB);
  endfunction

  // live count from elapsed state
  function automatic logic [CW-1:0] live_count(input chan_mode_e m,
      input logic [PW-1:0] per, input logic [CW-1:0] wrap_el,
      input logic [PW-1:0] ph);
    logic [PW:0] dbl;
    logic [PW-1:0] diff;
    case (m)
      M_RATE: begin
        diff = per - ph;
        return diff[CW-1:0];
      end
      M_SQUARE: begin
        dbl = {ph, 1'b0};
        if (dbl >= {1'b0, per}) dbl = dbl - {1'b0, per};
        diff = per - dbl[PW-1:0];
        return diff[CW-1:0];
      end
      default: return per[CW-1:0] - wrap_el;
    endcase
  endfunction

  function automatic logic wave_level(input chan_mode_e m,
      input logic [PW-1:0] per, input logic [EW-1:0] el,
      input logic [PW-1:0] ph);
    logic [PW-1:0] half;
    half = (per >> 1) + PW'(per[0]);
    case (m)
      M_TERM, M_ONESHOT: return el >= per;
      M_RATE:            return (ph == '0) && (el != '0);
      M_SQUARE:          return ph < half;
      default:           return el == per;
    endcase
  endfunction
endpackage

// File: rtl/intvl_gate_edge.sv
module intvl_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

  // R9 support: a rise cannot be seen two edges in a row
  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/intvl_tick_tracker.sv
module intvl_tick_tracker
  import intvl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          restart_i,
  input  logic          adv_i,
  input  logic [PW-1:0] per_i,
  output logic [EW-1:0] el_o,
  output logic [CW-1:0] wrap_o,
  output logic [PW-1:0] ph_o
);
  localparam logic [EW-1:0] EL_MAX = '1;

  logic [PW-1:0] ph_inc;
  assign ph_inc = ph_o + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_o   <= '0;
      wrap_o <= '0;
      ph_o   <= '0;
    end else if (load_i || restart_i) begin
      el_o   <= '0;
      wrap_o <= '0;
      ph_o   <= '0;
    end else if (adv_i) begin
      el_o   <= (el_o == EL_MAX) ? el_o : el_o + EW'(1);
      wrap_o <= wrap_o + CW'(1);
      ph_o   <= (ph_inc == per_i) ? '0 : ph_inc;
    end
  end

  p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (el_o == '0 && ph_o == '0 && wrap_o == '0));
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !restart_i && !adv_i) |=> ($stable(el_o) && $stable(ph_o)));
  p_phase_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i) |=> (ph_o < per_i));
endmodule

// File: rtl/intvl_out_shaper.sv
module intvl_out_shaper
  import intvl_pkg::*;
(
  input  logic          armed_i,
  input  chan_mode_e    mode_i,
  input  logic [PW-1:0] per_i,
  input  logic [EW-1:0] el_i,
  input  logic [CW-1:0] wrap_i,
  input  logic [PW-1:0] ph_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  always_comb begin
    if (!armed_i) begin
      out_o   = 1'b0;
      count_o = '0;
    end else begin
      out_o   = wave_level(mode_i, per_i, el_i, ph_i);
      count_o = live_count(mode_i, per_i, wrap_i, ph_i);
    end
  end
endmodule

// File: rtl/intvl_chan.sv
module intvl_chan
  import intvl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_stb,
  input  logic [15:0]   load_val,
  input  logic [2:0]    mode_sel,
  input  logic          gate,
  output logic          out,
  output logic [15:0]   count_val
);
  logic          armed;
  chan_mode_e    mode_q;
  logic [PW-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      mode_q <= M_TERM;
      per_q  <= PW'(1) << CW;
    end else if (load_stb) begin
      armed  <= 1'b1;
      mode_q <= fold_mode(mode_sel);
      per_q  <= period_of(load_val);
    end
  end

  // named events for checking
  logic gate_rise, restart_evt, adv_evt;

  intvl_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .rise_o(gate_rise));

  assign restart_evt = armed && gate_rise && gate_retrigs(mode_q);
  assign adv_evt     = armed && tick_en && (gate || !gate_pauses(mode_q));

  logic [EW-1:0] el;
  logic [CW-1:0] wrap_el;
  logic [PW-1:0] ph;

  intvl_tick_tracker u_track (
    .clk(clk), .rst_n(rst_n), .load_i(load_stb), .restart_i(restart_evt),
    .adv_i(adv_evt), .per_i(per_q), .el_o(el), .wrap_o(wrap_el), .ph_o(ph));

  intvl_out_shaper u_shape (
    .armed_i(armed), .mode_i(mode_q), .per_i(per_q), .el_i(el),
    .wrap_i(wrap_el), .ph_i(ph), .out_o(out), .count_o(count_val));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!out && count_val == '0));
  p_term_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode_q == M_TERM && out && !load_stb) |=> out);
  p_strobe_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode_q == M_SWSTRB || mode_q == M_HWSTRB) && out && adv_evt
     && !load_stb && !restart_evt) |=> !out);
  p_pause_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode_q == M_TERM && !gate && !load_stb) |=> $stable(count_val));
endmodule

// File: tb/intvl_chan_bench.sv
module intvl_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, load_stb = 1'b0, gate = 1'b1;
  logic [15:0] load_val = '0;
  logic [2:0] mode_sel = '0;
  logic out;
  logic [15:0] count_val;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  intvl_chan u_intvl_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
    .load_val(load_val), .mode_sel(mode_sel), .gate(gate),
    .out(out), .count_val(count_val));

  // {mode, period, ticks, exp_out, exp_count}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {3'd0, 16'd5, 8'd0, 1'b0, 16'd5},       // R4
    {3'd0, 16'd5, 8'd4, 1'b0, 16'd1},       // R4
    {3'd0, 16'd5, 8'd5, 1'b1, 16'd0},       // R4
    {3'd0, 16'd5, 8'd7, 1'b1, 16'hFFFE},    // R4
    {3'd1, 16'd3, 8'd3, 1'b1, 16'd0},       // R4
    {3'd2, 16'd4, 8'd3, 1'b0, 16'd1},       // R5
    {3'd2, 16'd4, 8'd4, 1'b1, 16'd4},       // R5
    {3'd2, 16'd4, 8'd5, 1'b0, 16'd3},       // R5
    {3'd3, 16'd6, 8'd2, 1'b1, 16'd2},       // R6
    {3'd3, 16'd6, 8'd3, 1'b0, 16'd6},       // R6
    {3'd3, 16'd5, 8'd2, 1'b1, 16'd1},       // R6
    {3'd3, 16'd5, 8'd3, 1'b0, 16'd4},       // R6
    {3'd4, 16'd3, 8'd3, 1'b1, 16'd0},       // R7
    {3'd4, 16'd3, 8'd4, 1'b0, 16'hFFFF},    // R7
    {3'd5, 16'd2, 8'd2, 1'b1, 16'd0},       // R7
    {3'd6, 16'd4, 8'd4, 1'b1, 16'd4},       // R10
    {3'd0, 16'd0, 8'd0, 1'b0, 16'd0},       // R2
    {3'd0, 16'd0, 8'd1, 1'b0, 16'hFFFF}     // R2
  };

  task automatic chk(input string req, input logic eo, input logic [15:0] ec);
    checks++;
    if (out !== eo || count_val !== ec) begin
      errors++;
      $display("FAIL %s out=%0b count=%h expected out=%0b count=%h",
               req, out, count_val, eo, ec);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    mode_sel = m; load_val = v; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 1'b0, 16'd0);
    ticks(3);
    chk("R1 ticks before load", 1'b0, 16'd0);

    for (int k = 0; k < NV; k++) begin
      do_load(VEC[k][43:41], VEC[k][40:25]);
      ticks(int'(VEC[k][24:17]));
      chk($sformatf("vector %0d (R2 R4 R5 R6 R7 R10)", k), VEC[k][16], VEC[k][15:0]);
    end

    // R3: reload mid-run with a tick in the load cycle
    do_load(3'd0, 16'd5);
    ticks(3);
    mode_sel = 3'd0; load_val = 16'd9; load_stb = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    chk("R3 load beats tick", 1'b0, 16'd9);
    ticks(1);
    chk("R3 resume next tick", 1'b0, 16'd8);

    // R11: no ticks, no change
    do_load(3'd2, 16'd4);
    ticks(2);
    repeat (5) @(negedge clk);
    chk("R11 hold without tick", 1'b0, 16'd2);

    // R8: gate low pauses mode 0, rise does not restart
    do_load(3'd0, 16'd4);
    gate = 1'b0;
    ticks(3);
    chk("R8 paused by gate", 1'b0, 16'd4);
    gate = 1'b1;
    ticks(2);
    chk("R8 no restart on rise", 1'b0, 16'd2);

    // R9: mode 1 restart on rise, level does not pause
    do_load(3'd1, 16'd4);
    ticks(3);
    chk("R9 before restart", 1'b0, 16'd1);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk("R9 restart on rise", 1'b0, 16'd4);
    gate = 1'b0;
    ticks(2);
    chk("R9 gate low keeps counting", 1'b0, 16'd2);
    gate = 1'b1;

    // R9: mode 3 restart
    do_load(3'd3, 16'd6);
    ticks(4);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk("R9 square restart", 1'b1, 16'd6);

    // R10: mode 7 acts as square wave
    do_load(3'd7, 16'd5);
    ticks(3);
    chk("R10 code 7 square", 1'b0, 16'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule